// File: doc/BRIEF.md
# External Bus Hand-Over Arbiter with Run-On Option

This block lets an outside master borrow the processor's external memory bus. The outside master raises an asynchronous request. The request passes through a chain of synchronizing flip-flops before the control logic acts on it. If the core has an external access in flight, the hand-over waits until that access has finished. The block then turns off the output drivers of every external bus group and raises the grant.

In the default mode the core is stalled for as long as the bus is away. When the run-on option is enabled, the core keeps running out of internal memory while the bus is granted. It stops only once it needs the external bus. At that point the hang flag tells the outside master that the core is blocked waiting for the bus. When the request is withdrawn, the grant and the hang flag drop together and the drivers return. A stalled core restarts one cycle after that.

Top module: `bus_handover_arb`

## Requirements
- R1: During and directly after reset, bus_grant, bus_hang and core_stall are 0 and every bit of drv_en is 1.
- R2: With no access in flight, a request that is held high shows as bus_grant=1 with all drv_en bits 0 after the third rising edge following the change of bus_req_async (two synchronizer stages plus the state register).
- R3: With run_on_en=0 at the moment of hand-over, core_stall rises in the same cycle as bus_grant and stays high for the whole grant.
- R4: While ext_access_busy is 1, no grant is given. The grant appears after the first rising edge at which ext_access_busy is sampled as 0 and the synchronized request is still present.
- R5: With run_on_en=1 at hand-over and ext_access_need=0, the bus is granted while core_stall and bus_hang stay 0.
- R6: In a run-on grant, ext_access_need=1 sampled at a rising edge sets core_stall=1 and bus_hang=1 after that edge.
- R7: Withdrawing the request clears bus_grant and bus_hang and sets all drv_en bits to 1 after the third rising edge that follows the change. If the core was stalled, core_stall stays 1 for exactly one more cycle.
- R8: A request withdrawn while the block is still waiting for an in-flight access returns the block to bus ownership without any grant.
- R9: If run_on_en drops during a run-on grant while ext_access_need=0, the core stalls at the next edge and bus_hang stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_async | input | 1 | Bus request from the outside master, asynchronous |
| run_on_en | input | 1 | 1 lets the core keep running while the bus is granted |
| ext_access_need | input | 1 | The core's current instruction needs the external bus |
| ext_access_busy | input | 1 | An external access is in flight |
| bus_grant | output | 1 | The bus has been handed over |
| bus_hang | output | 1 | The core is blocked waiting for the granted bus |
| drv_en | output | NUM_OE | Output-driver enables for the address, data, select and strobe groups (1 = driving) |
| core_stall | output | 1 | Holds the core's instruction execution |

## Verification
The arbiter is driven with random mixes of request, run-on, need and busy levels that are held for random lengths. This separates the halt path from the run-on path and catches grants that bypass the busy wait. Directed cases count the exact edge at which the grant rises and falls, which exposes a wrong synchronizer depth. They also withdraw the request while an access is still in flight, and drop run-on during a grant, so a stall caused by need can be told apart from one caused by the mode change. The extra stall cycle after release is checked on its own, apart from the grant edge.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
   typedef enum logic [1:0] {
      ST_OWN        = 2'd0,
      ST_WAIT_DONE  = 2'd1,
      ST_GRANT_RUN  = 2'd2,
      ST_GRANT_HALT = 2'd3
   } arb_state_t;

   function automatic logic is_granted(arb_state_t s);
      return (s == ST_GRANT_RUN) || (s == ST_GRANT_HALT);
   endfunction
endpackage

// File: rtl/busarb_req_sync.sv
module busarb_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("busarb_req_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];

   AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (chain_q[0] == $past(din)));                      // R2
endmodule

// File: rtl/busarb_fsm.sv
module busarb_fsm
   import busarb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_sync,
   input  logic       run_on_en,
   input  logic       need,
   input  logic       busy,
   output arb_state_t state_q,
   output logic       hang_q,
   output logic       resume_q
);
   arb_state_t state_d;
   logic       hang_d;

   function automatic arb_state_t grant_target(logic run_on);
      return run_on ? ST_GRANT_RUN : ST_GRANT_HALT;
   endfunction

   always_comb begin
      state_d = state_q;
      hang_d  = hang_q;
      unique case (state_q)
         ST_OWN: begin
            if (req_sync) state_d = busy ? ST_WAIT_DONE : grant_target(run_on_en);
         end
         ST_WAIT_DONE: begin
            if (!req_sync)  state_d = ST_OWN;
            else if (!busy) state_d = grant_target(run_on_en);
         end
         ST_GRANT_RUN: begin
            if (!req_sync) state_d = ST_OWN;
            else if (need || !run_on_en) begin
               state_d = ST_GRANT_HALT;
               hang_d  = need;
            end
         end
         ST_GRANT_HALT: begin
            if (!req_sync) begin
               state_d = ST_OWN;
               hang_d  = 1'b0;
            end
         end
         default: state_d = ST_OWN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_OWN;
         hang_q   <= 1'b0;
         resume_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         hang_q   <= hang_d;
         resume_q <= (state_q == ST_GRANT_HALT) && (state_d == ST_OWN);
      end
   end

   AST_GRANT_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (is_granted(state_q) && !is_granted($past(state_q))) |-> !$past(busy)); // R4
   AST_HANG_ONLY_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      hang_q |-> (state_q == ST_GRANT_HALT));                                  // R6
   AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      resume_q |=> !resume_q);                                                 // R7
   AST_WAIT_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == ST_WAIT_DONE && !$past(req_sync)) |-> (state_q == ST_OWN)); // R8
endmodule

// File: rtl/busarb_outputs.sv
module busarb_outputs
   import busarb_pkg::*;
#(
   parameter int NUM_OE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  arb_state_t        state_q,
   input  logic              hang_q,
   input  logic              resume_q,
   output logic              grant,
   output logic              hang,
   output logic              stall,
   output logic [NUM_OE-1:0] drv_en
);
   generate
      if (NUM_OE < 1) begin : g_bad_oe
         $error("busarb_outputs: NUM_OE must be at least 1");
      end
   endgenerate

   assign grant = is_granted(state_q);
   assign hang  = hang_q;
   assign stall = (state_q == ST_GRANT_HALT) || resume_q;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_OE; gi++) begin : g_oe
         assign drv_en[gi] = !is_granted(state_q);
      end
   endgenerate

   AST_GRANT_DRV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (drv_en == '0));                                               // R2
   AST_OWN_DRV_ON: assert property (@(posedge clk) disable iff (!rst_n)
      !grant |-> (&drv_en));                                                   // R7
endmodule

// File: rtl/bus_handover_arb.sv
module bus_handover_arb
   import busarb_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int NUM_OE      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req_async,
   input  logic              run_on_en,
   input  logic              ext_access_need,
   input  logic              ext_access_busy,
   output logic              bus_grant,
   output logic              bus_hang,
   output logic [NUM_OE-1:0] drv_en,
   output logic              core_stall
);
   logic       req_sync;
   arb_state_t state_q;
   logic       hang_q;
   logic       resume_q;

   busarb_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .din (bus_req_async), .dout (req_sync)
   );

   busarb_fsm u_fsm (
      .clk (clk), .rst_n (rst_n), .req_sync (req_sync), .run_on_en (run_on_en),
      .need (ext_access_need), .busy (ext_access_busy),
      .state_q (state_q), .hang_q (hang_q), .resume_q (resume_q)
   );

   busarb_outputs #(.NUM_OE(NUM_OE)) u_out (
      .clk (clk), .rst_n (rst_n), .state_q (state_q), .hang_q (hang_q),
      .resume_q (resume_q), .grant (bus_grant), .hang (bus_hang),
      .stall (core_stall), .drv_en (drv_en)
   );

   AST_HANG_IMPLIES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_hang |-> (bus_grant && core_stall));                                 // R6
   AST_RUN_NO_HANG: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_grant && !core_stall) |-> !bus_hang);                               // R5
   AST_STALL_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_grant) && $past(core_stall)) |-> core_stall);                 // R7
endmodule

// File: tb/sim_bus_handover_arb.sv
module sim_bus_handover_arb;
   localparam int CLK_PERIOD = 10;
   localparam int NOE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, run_on = 1'b0, need = 1'b0, busy = 1'b0;
   logic grant, hang, stall;
   logic [NOE-1:0] drv;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference model: 0 own, 1 waiting, 2 granted running, 3 granted halted
   int  m_st = 0;
   bit  m_s1 = 0, m_s2 = 0, m_hang = 0, m_resume = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_handover_arb #(.SYNC_STAGES(2), .NUM_OE(NOE)) u0 (
      .clk (clk), .rst_n (rst_n), .bus_req_async (req), .run_on_en (run_on),
      .ext_access_need (need), .ext_access_busy (busy),
      .bus_grant (grant), .bus_hang (hang), .drv_en (drv), .core_stall (stall)
   );

   function automatic bit exp_grant(); return m_st >= 2; endfunction
   function automatic bit exp_stall(); return (m_st == 3) || m_resume; endfunction

   task automatic model_reset();
      m_st = 0; m_s1 = 0; m_s2 = 0; m_hang = 0; m_resume = 0;
   endtask

   task automatic model_edge();
      int nst = m_st;
      bit nh = m_hang;
      case (m_st)
         0: if (m_s2) nst = busy ? 1 : (run_on ? 2 : 3);
         1: if (!m_s2) nst = 0; else if (!busy) nst = run_on ? 2 : 3;
         2: if (!m_s2) nst = 0; else if (need || !run_on) begin nst = 3; nh = need; end
         default: if (!m_s2) begin nst = 0; nh = 0; end
      endcase
      m_resume = (m_st == 3) && (nst == 0);
      m_st = nst; m_hang = nh;
      m_s2 = m_s1; m_s1 = req;
   endtask

   task automatic check(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic compare_model();
      check("R2", "grant vs model", grant, exp_grant());
      check("R2", "drv_en vs model", drv, exp_grant() ? 0 : (1 << NOE) - 1);
      check("R3", "stall vs model", stall, exp_stall());
      check("R6", "hang vs model", hang, m_hang);
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         model_edge();
         @(negedge clk);
         compare_model();
      end
   endtask

   task automatic set_in(bit r, bit g, bit nd, bit b);
      req = r; run_on = g; need = nd; busy = b;
   endtask

   task automatic release_bus();
      set_in(0, 0, 0, 0);
      step(6);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "grant in reset", grant, 0);
      check("R1", "stall in reset", stall, 0);
      check("R1", "hang in reset", hang, 0);
      check("R1", "drv_en in reset", drv, 15);
      rst_n = 1'b1;
      step(2);
      check("R1", "grant after reset", grant, 0);

      // R2 / R3: plain hand-over, run-on off
      set_in(1, 0, 0, 0);
      step(2);
      check("R2", "grant before third edge", grant, 0);
      step(1);
      check("R2", "grant at third edge", grant, 1);
      check("R2", "drivers off", drv, 0);
      check("R3", "stall with grant", stall, 1);
      step(4);
      check("R3", "stall held", stall, 1);
      // R7: release timing
      set_in(0, 0, 0, 0);
      step(2);
      check("R7", "grant held two edges", grant, 1);
      step(1);
      check("R7", "grant dropped", grant, 0);
      check("R7", "drivers back", drv, 15);
      check("R7", "stall tail", stall, 1);
      step(1);
      check("R7", "stall released", stall, 0);
      release_bus();

      // R4: wait for in-flight access
      set_in(1, 0, 0, 1);
      step(6);
      check("R4", "no grant while busy", grant, 0);
      set_in(1, 0, 0, 0);
      step(1);
      check("R4", "grant after busy clears", grant, 1);
      release_bus();

      // R8: withdraw while waiting
      set_in(1, 0, 0, 1);
      step(4);
      set_in(0, 0, 0, 1);
      step(4);
      set_in(0, 0, 0, 0);
      step(3);
      check("R8", "no grant after withdraw", grant, 0);
      check("R8", "drivers on after withdraw", drv, 15);
      release_bus();

      // R5 / R6: run-on grant then need
      set_in(1, 1, 0, 0);
      step(3);
      check("R5", "run-on grant", grant, 1);
      check("R5", "run-on no stall", stall, 0);
      check("R5", "run-on no hang", hang, 0);
      set_in(1, 1, 1, 0);
      step(1);
      check("R6", "need stalls", stall, 1);
      check("R6", "need hangs", hang, 1);
      set_in(0, 1, 1, 0);
      step(3);
      check("R7", "hang cleared on release", hang, 0);
      release_bus();

      // R9: run-on dropped during grant
      set_in(1, 1, 0, 0);
      step(4);
      set_in(1, 0, 0, 0);
      step(1);
      check("R9", "stall on mode drop", stall, 1);
      check("R9", "no hang on mode drop", hang, 0);
      release_bus();

      // random mix against the model
      void'($urandom(32'd1207));
      for (int k = 0; k < 400; k++) begin
         set_in($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 3) == 0,
                $urandom_range(0, 2) == 0);
         step($urandom_range(1, 8));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule